// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Detection

This block is a memory-mapped general-purpose I/O controller that serves a parameterised number of banks. Each bank has 32 pins. Software reaches it through a simple single-cycle register bus with separate read and write strobes. Each pin has an output latch and an output-enable. Its input is synchronised into the core clock domain. Rising and falling transitions on the synchronised input are recorded in a sticky status register.

Registers of one kind are grouped together. Within a group of three banks they sit in consecutive words, and each group of three banks starts on a new 256-byte page. The same offsets therefore repeat every 0x100 with an interleaved per-bank stride. Output latches change only through write-one-to-set and write-one-to-clear words. Edge-status bits are cleared by writing ones.

One combined interrupt reports every status bit that its detect-mask bit lets through. Pins 0 and 1 of bank 0 each also drive a dedicated interrupt line.

Top module: `gpio_banked_ctrl`

## Requirements
- R1: A register address is `((b / 3) << 8) + ((b % 3) << 2) + K`. Here b is the bank and K is the kind offset: level 0x00, direction 0x0C, set 0x18, clear 0x24, rise-enable 0x30, fall-enable 0x3C, edge-status 0x48, detect-mask 0x9C. Bit n of every register refers to pin n of bank b, which is global pin 32*b+n.
- R2: The direction register reads back what was last written to it. A 1 bit drives the matching `pin_oe` high, making the pin an output; a 0 bit makes it an input.
- R3: Writing the set word drives `pin_out` high for every 1 bit. Bits written as 0 keep their latch value.
- R4: Writing the clear word drives `pin_out` low for every 1 bit. Bits written as 0 keep their latch value.
- R5: The level register returns each pin's input after a two-flop synchroniser, whatever the direction setting. Writes to it have no effect.
- R6: With the rise enable set, a low-to-high transition of the synchronised input sets the pin's edge-status bit.
- R7: With the fall enable set, a high-to-low transition sets the status bit. With both enables set, either transition sets it. With neither set, no transition does.
- R8: An edge-status bit stays set until a 1 is written to it. Writing 0 leaves it unchanged.
- R9: `irq_combined` is high exactly when some status bit is set whose detect-mask bit is 1. It is registered one clock after the status.
- R10: `irq_pin0` and `irq_pin1` follow the status bits of bank 0 pins 0 and 1, independent of the detect mask, with one clock of registering.
- R11: When a new edge and a clearing write hit the same status bit in the same clock, the bit stays set.
- R12: All registers and outputs reset to 0. Reads of the set or clear words, of unmapped or misaligned offsets, and of absent banks return 0. Read data appears one clock after `bus_rd` and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32*NUM_BANKS | Asynchronous pin inputs |
| pin_out | output | 32*NUM_BANKS | Output latch values |
| pin_oe | output | 32*NUM_BANKS | Output enables (direction) |
| irq_combined | output | 1 | Masked OR of all edge-status bits |
| irq_pin0 | output | 1 | Dedicated interrupt of bank 0 pin 0 |
| irq_pin1 | output | 1 | Dedicated interrupt of bank 0 pin 1 |

## Verification
The bench builds the controller with four banks and a 10-bit address. The fourth bank lands at 0x100, so the jump to the second 256-byte page is exercised, and the absent fifth bank at 0x104 must read as zero. With only 128 pins, every pin can be swept through all four rise/fall enable combinations. The sweep checks both status and interrupts for each pin. Every register kind of every bank is also checked with computed patterns.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int PINS_PER_BANK = 32;
  localparam int BANKS_PER_PAGE = 3;
  localparam int PAGE_SHIFT = 8;
  localparam int LINEAR_KINDS = 7;
  localparam int MASK_WORD = 'h9C >> 2;

  typedef enum logic [2:0] {
    RK_LEVEL = 3'd0,
    RK_DIR   = 3'd1,
    RK_SET   = 3'd2,
    RK_CLR   = 3'd3,
    RK_RISE  = 3'd4,
    RK_FALL  = 3'd5,
    RK_STAT  = 3'd6,
    RK_MASK  = 3'd7
  } reg_kind_e;

  typedef struct packed {
    logic dir;
    logic set;
    logic clr;
    logic rise;
    logic fall;
    logic stat;
    logic mask;
  } wr_strobe_t;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] lvl_now,
  output logic [WIDTH-1:0] lvl_prev
);
  logic [WIDTH-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_now  = sync_q;
  assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_reg_decode.sv
module gpio_reg_decode
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 10,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [BANK_W-1:0] bank,
  output reg_kind_e         kind
);
  int   word_i, page_i, sub_i, bank_i;
  logic known;

  always_comb begin
    word_i = int'(addr[PAGE_SHIFT-1:2]);
    page_i = int'(addr[ADDR_W-1:PAGE_SHIFT]);
    kind   = RK_LEVEL;
    sub_i  = 0;
    known  = 1'b0;
    if (word_i < LINEAR_KINDS * BANKS_PER_PAGE) begin
      kind  = reg_kind_e'(3'(word_i / BANKS_PER_PAGE));
      sub_i = word_i % BANKS_PER_PAGE;
      known = 1'b1;
    end else if (word_i >= MASK_WORD && word_i < MASK_WORD + BANKS_PER_PAGE) begin
      kind  = RK_MASK;
      sub_i = word_i - MASK_WORD;
      known = 1'b1;
    end
    bank_i = page_i * BANKS_PER_PAGE + sub_i;
    hit    = known && (addr[1:0] == 2'b00) && (bank_i < NUM_BANKS);
    bank   = BANK_W'(bank_i);
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = PINS_PER_BANK
) (
  input  logic             clk,
  input  logic             rst,
  input  wr_strobe_t       wr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] lvl_now,
  input  logic [WIDTH-1:0] lvl_prev,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] out_q,
  output logic [WIDTH-1:0] rise_q,
  output logic [WIDTH-1:0] fall_q,
  output logic [WIDTH-1:0] stat_q,
  output logic [WIDTH-1:0] mask_q
);
  logic [WIDTH-1:0] rise_hit, fall_hit, edge_hit, clr_bits;

  always_comb begin
    rise_hit = rise_q & lvl_now & ~lvl_prev;
    fall_hit = fall_q & ~lvl_now & lvl_prev;
    edge_hit = rise_hit | fall_hit;
    clr_bits = wr.stat ? wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      stat_q <= '0;
      mask_q <= '0;
    end else begin
      if (wr.dir)  dir_q  <= wdata;
      if (wr.rise) rise_q <= wdata;
      if (wr.fall) fall_q <= wdata;
      if (wr.mask) mask_q <= wdata;
      if (wr.set)       out_q <= out_q | wdata;
      else if (wr.clr)  out_q <= out_q & ~wdata;
      stat_q <= (stat_q & ~clr_bits) | edge_hit;
    end
  end

  // R8: without a clearing write no status bit drops
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(wr.stat) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R11: a detected edge always lands, even with a concurrent clear
  a_r11_edge_wins: assert property (@(posedge clk) disable iff (rst)
    (edge_hit != '0) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

  // R3: ones written to the set word appear on the latches
  a_r3_set_drives: assert property (@(posedge clk) disable iff (rst)
    wr.set |=> ((out_q & $past(wdata)) == $past(wdata)));

  // R4: ones written to the clear word drop the latches
  a_r4_clr_drives: assert property (@(posedge clk) disable iff (rst)
    (wr.clr && !wr.set) |=> ((out_q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_banked_ctrl.sv
module gpio_banked_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 10,
  localparam int NPINS    = NUM_BANKS * PINS_PER_BANK,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_combined,
  output logic              irq_pin0,
  output logic              irq_pin1
);
  logic              dec_hit;
  logic [BANK_W-1:0] dec_bank;
  reg_kind_e         dec_kind;
  logic [NPINS-1:0]  lvl_now, lvl_prev;

  logic [31:0] lvl_a  [NUM_BANKS];
  logic [31:0] dir_a  [NUM_BANKS];
  logic [31:0] out_a  [NUM_BANKS];
  logic [31:0] rise_a [NUM_BANKS];
  logic [31:0] fall_a [NUM_BANKS];
  logic [31:0] stat_a [NUM_BANKS];
  logic [31:0] mask_a [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_pend, bank_any;

  gpio_reg_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit(dec_hit), .bank(dec_bank), .kind(dec_kind)
  );

  gpio_pin_sync #(.WIDTH(NPINS)) u_sync (
    .clk(clk), .rst(rst), .raw_in(pin_in), .lvl_now(lvl_now), .lvl_prev(lvl_prev)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    wr_strobe_t strobe;
    logic       sel;

    always_comb begin
      sel         = bus_wr && dec_hit && (dec_bank == BANK_W'(b));
      strobe.dir  = sel && (dec_kind == RK_DIR);
      strobe.set  = sel && (dec_kind == RK_SET);
      strobe.clr  = sel && (dec_kind == RK_CLR);
      strobe.rise = sel && (dec_kind == RK_RISE);
      strobe.fall = sel && (dec_kind == RK_FALL);
      strobe.stat = sel && (dec_kind == RK_STAT);
      strobe.mask = sel && (dec_kind == RK_MASK);
    end

    gpio_bank_regs #(.WIDTH(PINS_PER_BANK)) u_regs (
      .clk(clk), .rst(rst), .wr(strobe), .wdata(bus_wdata),
      .lvl_now(lvl_now[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .lvl_prev(lvl_prev[b*PINS_PER_BANK +: PINS_PER_BANK]),
      .dir_q(dir_a[b]), .out_q(out_a[b]), .rise_q(rise_a[b]),
      .fall_q(fall_a[b]), .stat_q(stat_a[b]), .mask_q(mask_a[b])
    );

    assign lvl_a[b]     = lvl_now[b*PINS_PER_BANK +: PINS_PER_BANK];
    assign pin_out[b*PINS_PER_BANK +: PINS_PER_BANK] = out_a[b];
    assign pin_oe[b*PINS_PER_BANK +: PINS_PER_BANK]  = dir_a[b];
    assign bank_pend[b] = |(stat_a[b] & mask_a[b]);
    assign bank_any[b]  = |stat_a[b];
  end

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (dec_hit) begin
      case (dec_kind)
        RK_LEVEL: rd_val = lvl_a[dec_bank];
        RK_DIR:   rd_val = dir_a[dec_bank];
        RK_RISE:  rd_val = rise_a[dec_bank];
        RK_FALL:  rd_val = fall_a[dec_bank];
        RK_STAT:  rd_val = stat_a[dec_bank];
        RK_MASK:  rd_val = mask_a[dec_bank];
        default:  rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata    <= '0;
      irq_combined <= 1'b0;
      irq_pin0     <= 1'b0;
      irq_pin1     <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_val;
      irq_combined <= |bank_pend;
      irq_pin0     <= stat_a[0][0];
      irq_pin1     <= stat_a[0][1];
    end
  end

  // R12: read data only moves on a read strobe
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> $stable(bus_rdata));

  // R9: the combined line rises only after some status bit was set
  a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_combined) |-> $past(|bank_any));
endmodule

// File: tb/gpio_banked_ctrl_test.sv
module gpio_banked_ctrl_test;
  localparam int NB = 4;
  localparam int AW = 10;
  localparam int NP = NB * 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic irq_combined, irq_pin0, irq_pin1;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gpio_banked_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_combined(irq_combined), .irq_pin0(irq_pin0), .irq_pin1(irq_pin1)
  );

  localparam int K_LVL = 'h00, K_DIR = 'h0C, K_SET = 'h18, K_CLR = 'h24;
  localparam int K_RISE = 'h30, K_FALL = 'h3C, K_STAT = 'h48, K_MASK = 'h9C;

  function automatic int ra(int b, int k);
    return ((b / 3) << 8) + ((b % 3) << 2) + k;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, pat, lat;
    settle(3);
    rst = 1'b0;
    settle(1);

    // R12 reset state
    for (int b = 0; b < NB; b++) begin
      rd(ra(b, K_DIR), v);  check("R12 reset dir", v, 0);
      rd(ra(b, K_STAT), v); check("R12 reset stat", v, 0);
      rd(ra(b, K_MASK), v); check("R12 reset mask", v, 0);
      rd(ra(b, K_RISE), v); check("R12 reset rise", v, 0);
    end
    check("R12 reset outputs", {pin_out[31:0] | pin_oe[31:0]}, 0);
    check("R12 reset irqs", {29'd0, irq_combined, irq_pin0, irq_pin1}, 0);

    // R1 R2 map and direction
    for (int b = 0; b < NB; b++) wr(ra(b, K_DIR), 32'hC3A5_0F00 ^ (32'h0101_0101 * (b + 1)));
    for (int b = 0; b < NB; b++) begin
      pat = 32'hC3A5_0F00 ^ (32'h0101_0101 * (b + 1));
      rd(ra(b, K_DIR), v); check("R1 R2 dir readback", v, pat);
      check("R2 pin_oe", pin_oe[b*32 +: 32], pat);
    end
    for (int b = 0; b < NB; b++) begin
      wr(ra(b, K_RISE), 32'h1111_0000 + b);
      wr(ra(b, K_FALL), 32'h0000_2222 + (b << 20));
    end
    for (int b = 0; b < NB; b++) begin
      rd(ra(b, K_RISE), v); check("R1 rise map", v, 32'h1111_0000 + b);
      rd(ra(b, K_FALL), v); check("R1 fall map", v, 32'h0000_2222 + (b << 20));
      wr(ra(b, K_RISE), 0); wr(ra(b, K_FALL), 0); wr(ra(b, K_DIR), 0);
    end

    // R3 R4 set/clear
    for (int b = 0; b < NB; b++) begin
      lat = 0;
      for (int s = 0; s < 4; s++) begin
        pat = 32'h9E37_79B9 * (s + 1) + b;
        wr(ra(b, K_SET), pat); lat = lat | pat;
        check("R3 set", pin_out[b*32 +: 32], lat);
        pat = 32'h7F4A_7C15 * (s + 3) ^ b;
        wr(ra(b, K_CLR), pat); lat = lat & ~pat;
        check("R4 clear", pin_out[b*32 +: 32], lat);
      end
      wr(ra(b, K_CLR), 32'hFFFF_FFFF);
      check("R4 clear all", pin_out[b*32 +: 32], 0);
    end

    // R12 write-only, unmapped, absent bank
    wr(ra(0, K_SET), 32'h0000_00FF);
    rd(ra(0, K_SET), v); check("R12 set reads 0", v, 0);
    rd(ra(0, K_CLR), v); check("R12 clear reads 0", v, 0);
    rd('h060, v); check("R12 unmapped reads 0", v, 0);
    wr(ra(4, K_DIR), 32'hFFFF_FFFF);
    rd(ra(4, K_DIR), v); check("R12 absent bank reads 0", v, 0);
    check("R12 absent bank no side effect", pin_oe[31:0], 0);
    wr(ra(0, K_DIR) + 1, 32'hFFFF_FFFF);
    rd(ra(0, K_DIR), v); check("R12 misaligned write ignored", v, 0);
    rd(ra(0, K_DIR) + 2, v); check("R12 misaligned read 0", v, 0);
    wr(ra(0, K_CLR), 32'hFFFF_FFFF);

    // R5 level, regardless of direction
    wr(ra(1, K_DIR), 32'hFFFF_0000);
    for (int s = 0; s < 3; s++) begin
      @(negedge clk);
      for (int b = 0; b < NB; b++) pins[b*32 +: 32] = 32'hA5F0_3C96 * (s + 2) + b;
      settle(2);
      for (int b = 0; b < NB; b++) begin
        rd(ra(b, K_LVL), v); check("R5 level", v, 32'hA5F0_3C96 * (s + 2) + b);
      end
    end
    wr(ra(2, K_LVL), 32'h0);
    rd(ra(2, K_LVL), v); check("R5 level write ignored", v, 32'hA5F0_3C96 * 4 + 2);
    wr(ra(1, K_DIR), 0);
    @(negedge clk); pins = '0; settle(4);

    // R6 R7 R8 R9 R10 sweep of every pin and enable combination
    for (int b = 0; b < NB; b++) wr(ra(b, K_MASK), 32'hFFFF_FFFF);
    for (int b = 0; b < NB; b++) wr(ra(b, K_STAT), 32'hFFFF_FFFF);
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 4; m++) begin
        logic [31:0] bit_p, er, ef;
        int bk;
        bk = p / 32;
        bit_p = 32'h1 << (p % 32);
        er = m[0] ? bit_p : 0;
        ef = m[1] ? bit_p : 0;
        wr(ra(bk, K_RISE), er);
        wr(ra(bk, K_FALL), ef);
        @(negedge clk); pins[p] = 1'b1; settle(4);
        rd(ra(bk, K_STAT), v); check("R6 rising status", v, er);
        check("R9 irq after rise", {31'd0, irq_combined}, {31'd0, er != 0});
        if (p == 0) check("R10 irq_pin0 rise", {31'd0, irq_pin0}, {31'd0, er != 0});
        if (p == 1) check("R10 irq_pin1 rise", {31'd0, irq_pin1}, {31'd0, er != 0});
        wr(ra(bk, K_STAT), 0);
        rd(ra(bk, K_STAT), v); check("R8 zero write keeps", v, er);
        wr(ra(bk, K_STAT), 32'hFFFF_FFFF);
        @(negedge clk); pins[p] = 1'b0; settle(4);
        rd(ra(bk, K_STAT), v); check("R7 falling status", v, ef);
        wr(ra(bk, K_STAT), 32'hFFFF_FFFF);
        settle(1);
        check("R8 cleared irq", {31'd0, irq_combined}, 0);
      end
      wr(ra(p / 32, K_RISE), 0);
      wr(ra(p / 32, K_FALL), 0);
    end

    // R9 masking, R10 independent of mask
    wr(ra(0, K_MASK), 32'h0);
    wr(ra(0, K_RISE), 32'h1);
    @(negedge clk); pins[0] = 1'b1; settle(4);
    check("R9 masked irq low", {31'd0, irq_combined}, 0);
    check("R10 pin0 ignores mask", {31'd0, irq_pin0}, 1);
    wr(ra(0, K_MASK), 32'h1); settle(1);
    check("R9 unmask raises irq", {31'd0, irq_combined}, 1);

    // R11 edge and clear in the same cycle
    wr(ra(0, K_RISE), 32'h1); wr(ra(0, K_FALL), 32'h1);
    @(negedge clk); pins[0] = 1'b0;
    @(negedge clk);
    wr(ra(0, K_STAT), 32'h1);
    rd(ra(0, K_STAT), v); check("R11 edge beats clear", v, 32'h1);
    wr(ra(0, K_STAT), 32'h1);
    rd(ra(0, K_STAT), v); check("R11 plain clear", v, 0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule